// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block is one programmable cell of a lookup-table fabric. A sixteen-entry truth table, held in configuration storage, gives the value of any Boolean function of four logic inputs. The four inputs form an index, with `sel_in[3]` the most significant bit, that selects one stored bit as the combinational result. A flip-flop beside the table can register that result. One further configuration bit chooses whether the cell drives its registered or its combinational value.

Configuration arrives in one of two ways, and only while `cfg_en` is high. Bits can be shifted in serially, one per clock. A serial output lets several cells share one configuration chain. Alternatively, the whole table and the output-select bit can be written in a single clock. Loading new contents later turns the same cell into a different function. While configuration is in progress the cell output is held at 0, so a half-loaded table never reaches the fabric. The flip-flop is frozen during this time.

The reset input is asserted asynchronously and released through a two-stage synchronizer. All state therefore stays cleared for two clock edges after `rst_n` rises.

Top module: `cfg_logic_cell`

## Requirements
- R1: After reset the table holds all zeros and the output select is 0 (combinational). `cell_out` and `cfg_sdo` are 0, and the flip-flop holds 0.
- R2: A serial shift happens on each clock with `cfg_en`=1 and `cfg_wr`=0. The 17-bit chain {select, table[15:0]} moves one place toward the select bit, and `cfg_sdi` enters table bit 0. After 17 shifts, the first bit shifted in sits in the select bit and the last bit sits in table bit 0.
- R3: `cfg_sdo` shows the chain's top bit, which is the output-select bit. After each shift it therefore carries the bit that was previously in table bit 15.
- R4: On a clock with `cfg_en`=1 and `cfg_wr`=1, the select bit loads from `cfg_wmode` and the table loads from `cfg_wtable`. The bit of `cfg_wtable` at index k is the table entry for `sel_in`=k. A parallel write takes priority over a shift.
- R5: While `cfg_en`=0, the configuration does not change, whatever `cfg_sdi`, `cfg_wr`, `cfg_wmode` and `cfg_wtable` do.
- R6: With `cfg_en`=0 and select 0, `cell_out` equals table[`sel_in`] combinationally. For example, table 0xF888 gives `cell_out` = (s3 & s2) | (s1 & s0).
- R7: While `cfg_en`=1, `cell_out` is 0.
- R8: With select 1 and `cfg_en`=0, `cell_out` is the flip-flop output. On a clock with `cfg_en`=0, `ff_srst`=0 and `ff_ce`=1, the flip-flop loads table[`sel_in`]. With `ff_ce`=0 it holds its value.
- R9: On a clock with `cfg_en`=0 and `ff_srst`=1, the flip-flop clears to 0, whatever the value of `ff_ce`.
- R10: On a clock with `cfg_en`=1, the flip-flop holds its value, whatever the values of `ff_ce` and `ff_srst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Configuration in progress; enables shift or write and forces the output low |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_wr | input | 1 | Parallel write strobe (with `cfg_en`) |
| cfg_wmode | input | 1 | Output select for a parallel write: 0 combinational, 1 registered |
| cfg_wtable | input | 16 | Truth table for a parallel write |
| sel_in | input | 4 | Logic inputs forming the table index |
| ff_ce | input | 1 | Flip-flop clock enable |
| ff_srst | input | 1 | Flip-flop synchronous clear |
| cfg_sdo | output | 1 | Serial configuration data out, toward the next cell |
| cell_out | output | 1 | Cell output |

## Verification
The hardest state to reach from the ports is a flip-flop holding a known value through a configuration pass. The stimulus drives `ff_ce` and `ff_srst` high during that pass, so a wrong update would change the value. The value is only visible at `cell_out` once configuration ends and registered mode is selected. To get there, the stimulus first loads a table with a known entry and clocks it into the flip-flop. It then rewrites identical contents with both flip-flop controls asserted, and finally reads the output with `ff_ce` low. The serial path needs a similar approach: the order of bits along the chain is seen only through `cfg_sdo` and through a full sweep of all sixteen indices after a 17-bit load.

// File: rtl/cell_pkg.sv
package cell_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  function automatic int table_size(input int sel_w);
    return 1 << sel_w;
  endfunction

endpackage

// File: rtl/cell_rst_sync.sv
module cell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/cell_cfg_store.sv
module cell_cfg_store #(
  parameter int SEL_W = 4,
  localparam int TBL  = 1 << SEL_W
) (
  input  logic           clk,
  input  logic           rst_ok,
  input  logic           cfg_en,
  input  logic           cfg_sdi,
  input  logic           cfg_wr,
  input  logic           cfg_wmode,
  input  logic [TBL-1:0] cfg_wtable,
  output logic [TBL:0]   chain_q,
  output logic           cfg_sdo
);

  logic [TBL:0] chain_d;

  // Next state: a parallel write wins over a serial shift.
  always_comb begin
    chain_d = chain_q;
    if (cfg_wr) begin
      chain_d = {cfg_wmode, cfg_wtable};
    end else begin
      chain_d = {chain_q[TBL-1:0], cfg_sdi};
    end
  end

  // The configuration only moves while cfg_en is high.
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      chain_q <= '0;
    end else if (cfg_en) begin
      chain_q <= chain_d;
    end
  end

  assign cfg_sdo = chain_q[TBL];

endmodule

// File: rtl/cell_lut_mux.sv
module cell_lut_mux #(
  parameter int SEL_W = 4,
  localparam int TBL  = 1 << SEL_W,
  localparam int NODES = 2 * TBL - 1
) (
  input  logic [TBL-1:0]   tbl,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);

  // Heap-ordered binary tree. The leaves hold the table in index order,
  // and the root splits on the most significant select bit.
  logic [NODES-1:0] nd;

  for (genvar gk = 0; gk < TBL; gk++) begin : g_leaf
    assign nd[TBL-1+gk] = tbl[gk];
  end

  for (genvar gi = 0; gi < TBL - 1; gi++) begin : g_node
    localparam int DEPTH = $clog2(gi + 2) - 1;
    assign nd[gi] = sel[SEL_W-1-DEPTH] ? nd[2*gi+2] : nd[2*gi+1];
  end

  assign bit_out = nd[0];

endmodule

// File: rtl/cell_out_stage.sv
module cell_out_stage
  import cell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ok,
  input  logic      cfg_en,
  input  logic      ff_ce,
  input  logic      ff_srst,
  input  out_mode_e mode,
  input  logic      comb_bit,
  output logic      ff_q,
  output logic      cell_out
);

  logic ff_d;
  logic ff_ld;

  // A synchronous clear takes priority over the enable.
  // Nothing updates while configuration is in progress.
  always_comb begin
    ff_ld = !cfg_en && (ff_srst || ff_ce);
    ff_d  = ff_srst ? 1'b0 : comb_bit;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ff_q <= 1'b0;
    end else if (ff_ld) begin
      ff_q <= ff_d;
    end
  end

  always_comb begin
    if (cfg_en) begin
      cell_out = 1'b0;
    end else if (mode == OUT_REG) begin
      cell_out = ff_q;
    end else begin
      cell_out = comb_bit;
    end
  end

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cell_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_en,
  input  logic                    cfg_sdi,
  input  logic                    cfg_wr,
  input  logic                    cfg_wmode,
  input  logic [(1<<SEL_W)-1:0]   cfg_wtable,
  input  logic [SEL_W-1:0]        sel_in,
  input  logic                    ff_ce,
  input  logic                    ff_srst,
  output logic                    cfg_sdo,
  output logic                    cell_out
);

  localparam int TBL = table_size(SEL_W);

  logic         rst_ok;
  logic [TBL:0] cfg_vec;
  logic         comb_bit;
  logic         ff_q;
  out_mode_e    mode;

  cell_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  cell_cfg_store #(.SEL_W(SEL_W)) u_store (
    .clk        (clk),
    .rst_ok     (rst_ok),
    .cfg_en     (cfg_en),
    .cfg_sdi    (cfg_sdi),
    .cfg_wr     (cfg_wr),
    .cfg_wmode  (cfg_wmode),
    .cfg_wtable (cfg_wtable),
    .chain_q    (cfg_vec),
    .cfg_sdo    (cfg_sdo)
  );

  assign mode = out_mode_e'(cfg_vec[TBL]);

  cell_lut_mux #(.SEL_W(SEL_W)) u_mux (
    .tbl     (cfg_vec[TBL-1:0]),
    .sel     (sel_in),
    .bit_out (comb_bit)
  );

  cell_out_stage u_out (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .cfg_en   (cfg_en),
    .ff_ce    (ff_ce),
    .ff_srst  (ff_srst),
    .mode     (mode),
    .comb_bit (comb_bit),
    .ff_q     (ff_q),
    .cell_out (cell_out)
  );

endmodule

// File: rtl/cell_chk.sv
module cell_chk #(
  parameter int SEL_W = 4,
  localparam int TBL  = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             cfg_en,
  input logic             cfg_sdi,
  input logic             cfg_wr,
  input logic             cfg_wmode,
  input logic [TBL-1:0]   cfg_wtable,
  input logic [SEL_W-1:0] sel_in,
  input logic             ff_ce,
  input logic             ff_srst,
  input logic [TBL:0]     cfg_vec,
  input logic             ff_q,
  input logic             cfg_sdo,
  input logic             cell_out
);

  logic [TBL-1:0] tbl_v;
  assign tbl_v = cfg_vec[TBL-1:0];

  assert_shift_chain_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_en && !cfg_wr) |=> cfg_vec == {$past(cfg_vec[TBL-1:0]), $past(cfg_sdi)});

  assert_sdo_follows_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_en && !cfg_wr) |=> cfg_sdo == $past(cfg_vec[TBL-1]));

  assert_parallel_write_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_en && cfg_wr) |=> cfg_vec == {$past(cfg_wmode), $past(cfg_wtable)});

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_en |=> $stable(cfg_vec));

  assert_comb_lookup_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cfg_en && !cfg_vec[TBL]) |-> cell_out == tbl_v[sel_in]);

  assert_out_forced_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_en |-> !cell_out);

  assert_ff_load_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cfg_en && !ff_srst && ff_ce) |=> ff_q == $past(tbl_v[sel_in]));

  assert_ff_clear_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cfg_en && ff_srst) |=> !ff_q);

  assert_ff_frozen_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_en |=> $stable(ff_q));

endmodule

bind cfg_logic_cell cell_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .cfg_en     (cfg_en),
  .cfg_sdi    (cfg_sdi),
  .cfg_wr     (cfg_wr),
  .cfg_wmode  (cfg_wmode),
  .cfg_wtable (cfg_wtable),
  .sel_in     (sel_in),
  .ff_ce      (ff_ce),
  .ff_srst    (ff_srst),
  .cfg_vec    (cfg_vec),
  .ff_q       (ff_q),
  .cfg_sdo    (cfg_sdo),
  .cell_out   (cell_out)
);

// File: tb/test_cfg_logic_cell.sv
module test_cfg_logic_cell;

  localparam int SEL_W = 4;
  localparam int TBL   = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_en, cfg_sdi, cfg_wr, cfg_wmode;
  logic [TBL-1:0] cfg_wtable;
  logic [3:0]     sel_in;
  logic           ff_ce, ff_srst;
  logic           cfg_sdo, cell_out;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  logic [15:0] m_tbl;
  logic        m_mode;
  logic        m_ff;

  always #10 clk = ~clk;

  cfg_logic_cell #(.SEL_W(SEL_W)) i_cfg_logic_cell (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sdi(cfg_sdi),
    .cfg_wr(cfg_wr), .cfg_wmode(cfg_wmode), .cfg_wtable(cfg_wtable),
    .sel_in(sel_in), .ff_ce(ff_ce), .ff_srst(ff_srst),
    .cfg_sdo(cfg_sdo), .cell_out(cell_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (sel=%0d t=%0t)", tag, what, act, exp, sel_in, $time);
    end
  endtask

  function automatic logic model_out();
    if (cfg_en) return 1'b0;
    if (m_mode) return m_ff;
    return m_tbl[sel_in];
  endfunction

  // Called at a falling edge with new inputs applied: check, clock, update model.
  task automatic cyc(input string tag);
    #1;
    chk(tag, cell_out, model_out(), "cell_out");
    chk("R3", cfg_sdo, m_mode, "cfg_sdo");
    @(posedge clk);
    if (cfg_en) begin
      if (cfg_wr) {m_mode, m_tbl} = {cfg_wmode, cfg_wtable};
      else        {m_mode, m_tbl} = {m_tbl, cfg_sdi};
    end else if (ff_srst) begin
      m_ff = 1'b0;
    end else if (ff_ce) begin
      m_ff = m_tbl[sel_in];
    end
    @(negedge clk);
  endtask

  task automatic shift_load(input logic mode, input logic [15:0] t);
    logic [16:0] w;
    w = {mode, t};
    cfg_en = 1'b1; cfg_wr = 1'b0;
    for (int i = 16; i >= 0; i--) begin
      cfg_sdi = w[i];
      cyc("R7");
    end
    cfg_en = 1'b0; cfg_sdi = 1'b0;
  endtask

  task automatic par_load(input logic mode, input logic [15:0] t);
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_wmode = mode; cfg_wtable = t;
    cfg_sdi = ~t[15];
    cyc("R4");
    cfg_en = 1'b0; cfg_wr = 1'b0; cfg_sdi = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 16; s++) begin
      sel_in = 4'(s);
      cyc(tag);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; cfg_en = 0; cfg_sdi = 0; cfg_wr = 0; cfg_wmode = 0;
    cfg_wtable = '0; sel_in = '0; ff_ce = 0; ff_srst = 0;
    m_tbl = '0; m_mode = 1'b0; m_ff = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc("R1");
    // R1: reset state seen at the ports
    chk("R1", cell_out, 1'b0, "cell_out after reset");
    chk("R1", cfg_sdo, 1'b0, "cfg_sdo after reset");

    // R2/R6: serial load of (s3&s2)|(s1&s0), combinational select
    shift_load(1'b0, 16'hF888);
    for (int s = 0; s < 16; s++) begin
      sel_in = 4'(s);
      #1;
      chk("R6", cell_out, (sel_in[3] & sel_in[2]) | (sel_in[1] & sel_in[0]), "formula");
      cyc("R2");
    end

    // R3: shifting out the chain; sdo shows successive table bits
    cfg_en = 1'b1;
    for (int i = 0; i < 17; i++) begin
      cfg_sdi = 1'(i & 1);
      cyc("R7");
    end
    cfg_en = 1'b0;
    sweep("R2");

    // R5: configuration inputs ignored while cfg_en is low
    par_load(1'b0, 16'h6996);
    for (int i = 0; i < 6; i++) begin
      cfg_sdi = 1'(i & 1); cfg_wr = 1'b1; cfg_wmode = 1'b1; cfg_wtable = 16'h1234;
      cyc("R5");
    end
    cfg_wr = 1'b0;
    sweep("R5");

    // R4: write wins over shift
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_wmode = 1'b1; cfg_wtable = 16'h00FF; cfg_sdi = 1'b1;
    cyc("R4");
    cfg_en = 1'b0; cfg_wr = 1'b0;

    // R8: registered mode, output lags by one clock
    ff_ce = 1'b1;
    sweep("R8");
    ff_ce = 1'b0;
    sel_in = 4'd0;
    repeat (3) cyc("R8");

    // R9: clear beats enable
    sel_in = 4'd7;
    ff_ce = 1'b1;
    cyc("R8");
    chk("R8", cell_out, 1'b1, "ff loaded from entry 7");
    ff_srst = 1'b1;
    cyc("R9");
    chk("R9", cell_out, 1'b0, "ff cleared");
    ff_srst = 1'b0;
    cyc("R8");

    // R10: ff frozen during configuration even with ce and clear asserted
    sel_in = 4'd3;
    cyc("R8");
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_wmode = 1'b1; cfg_wtable = 16'h00FF;
    ff_srst = 1'b1; ff_ce = 1'b1;
    repeat (3) cyc("R10");
    cfg_en = 1'b0; cfg_wr = 1'b0; ff_srst = 1'b0; ff_ce = 1'b0;
    #1;
    chk("R10", cell_out, 1'b1, "ff held through configuration");
    cyc("R10");

    // Mixed traffic
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(1, 0) == 1)
        par_load(1'($urandom_range(1, 0)), 16'($urandom));
      else
        shift_load(1'($urandom_range(1, 0)), 16'($urandom));
      for (int k = 0; k < 10; k++) begin
        sel_in  = 4'($urandom_range(15, 0));
        ff_ce   = 1'($urandom_range(1, 0));
        ff_srst = ($urandom_range(7, 0) == 0);
        cyc(m_mode ? "R8" : "R6");
      end
      ff_ce = 1'b0; ff_srst = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule